// File: doc/BRIEF.md
# Logic Analyzer Capture Core

This block is the on-chip half of an embedded logic analyzer. Once armed, it writes one word of probe data into a circular sample memory on every rising edge of the sample clock. It watches each sample against a chain of trigger stages. When the last stage fires, it keeps recording only until the trigger sample sits at the chosen place in the window. Then it stops writing and keeps the memory unchanged for download.

The host writes a condition word per stage, a stage count and a trigger position, then pulses the arm input. The host polls `busy` and `done`. After `done` it reads the window through a one-cycle-latency read port. That port already puts the samples in time order, so read address 0 is the oldest sample. The host then arms again for the next capture. The condition words are expected to stay stable while a capture runs. The stage count and the position are latched when the core is armed.

Top module: `la_capture_core`

## Requirements
- R1: After an arm pulse, the first sample is taken on the next rising clock edge. The core then stores one probe sample per clock as a ring. The sample with index i since arming goes to physical address i mod DEPTH, so newer samples overwrite older ones.
- R2: A stage matches only when every probe bit satisfies its own 3-bit code in the same clock cycle.
- R3: Each bit takes a 3-bit code at bits [3b+2:3b] of its stage word. 0 means don't-care, 1 means low, 2 means high, 3 means rising and 4 means falling. Codes 5 to 7 act as don't-care. Rising and falling compare the bit with its value on the previous clock.
- R4: The stage word for stage s lies at `trig_cond[s*3*PROBE_W +: 3*PROBE_W]`. Stages must match one after another on distinct samples, in order 0, 1 and onward. Only a match of the last stage fires the trigger. A stage count of 0 acts as 1, and a count above STAGES acts as STAGES.
- R5: `trig_pos` sets how many samples come before the trigger sample. The value 0 gives DEPTH/8, 1 gives DEPTH/2, 2 gives 7*DEPTH/8 and 3 gives DEPTH/2.
- R6: Stage matching is ignored until that pre-trigger number of samples has been written since the arm pulse.
- R7: The trigger sample and DEPTH minus the pre-trigger count minus 1 further samples are stored. Then `done` rises and `busy` falls. After that the memory and `trig_addr` stay unchanged, whatever the probe does.
- R8: With `rd_en` high, `rd_data` on the next cycle holds the window sample at `rd_addr`. Address 0 is the oldest sample and the pre-trigger count is the trigger sample. `rd_valid` is `rd_en` delayed by one cycle.
- R9: `trig_addr` holds the physical memory address of the trigger sample.
- R10: An arm pulse clears `done`, resets the stage sequence and restarts capture from address 0. This holds even while a capture is busy. On the next cycle `busy` is 1 and `done` is 0.
- R11: During reset, `busy`, `done`, `trig_addr` and `rd_valid` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | sample clock |
| rst_n | input | 1 | asynchronous active-low reset |
| arm | input | 1 | one-cycle start or restart command |
| probe | input | PROBE_W | signals under observation |
| trig_cond | input | STAGES*3*PROBE_W | per-stage per-bit condition codes |
| n_stages | input | $clog2(STAGES+1) | number of sequential stages, latched at arm |
| trig_pos | input | 2 | trigger position select, latched at arm |
| rd_en | input | 1 | read request |
| rd_addr | input | log2(DEPTH) | window-relative read address |
| busy | output | 1 | capture in progress |
| done | output | 1 | window frozen and ready |
| trig_addr | output | log2(DEPTH) | physical address of the trigger sample |
| rd_valid | output | 1 | read data valid |
| rd_data | output | PROBE_W | read sample |

## Verification
The assertions assume that `arm` is a single-cycle pulse and that `rd_en` is a plain level with no handshake. They also assume the host has no way to stall the core. The bench drives every input on the falling edge and holds `arm` high for exactly one cycle. It keeps `trig_cond`, `n_stages` and `trig_pos` fixed from the arm pulse until `done`. It only reads back once capture has frozen. Its reference model knows the probe value in the arm cycle, because it drives 0 there.

// File: rtl/la_pkg.sv
package la_pkg;

   typedef enum logic [2:0] {
      COND_ANY  = 3'd0,
      COND_LOW  = 3'd1,
      COND_HIGH = 3'd2,
      COND_RISE = 3'd3,
      COND_FALL = 3'd4
   } la_cond_e;

   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_PRE  = 2'd1,
      ST_POST = 2'd2,
      ST_DONE = 2'd3
   } la_state_e;

   localparam logic [1:0] POS_EARLY  = 2'd0;
   localparam logic [1:0] POS_MIDDLE = 2'd1;
   localparam logic [1:0] POS_LATE   = 2'd2;

   // samples kept ahead of the trigger for a given position code
   function automatic int unsigned pre_count(int unsigned depth, logic [1:0] pos);
      case (pos)
         POS_EARLY: return depth / 8;
         POS_LATE:  return (depth / 8) * 7;
         default:   return depth / 2;
      endcase
   endfunction

endpackage

// File: rtl/la_trig_match.sv
module la_trig_match
   import la_pkg::*;
#(
   parameter int PROBE_W = 8,
   localparam int CW = 3 * PROBE_W
) (
   input  logic [PROBE_W-1:0] cur_i,
   input  logic [PROBE_W-1:0] prev_i,
   input  logic [CW-1:0]      cond_i,
   output logic               hit_o
);

   logic [PROBE_W-1:0] bit_ok;

   for (genvar b = 0; b < PROBE_W; b++) begin : g_bit
      always_comb begin
         case (cond_i[3*b +: 3])
            COND_LOW:  bit_ok[b] = ~cur_i[b];
            COND_HIGH: bit_ok[b] = cur_i[b];
            COND_RISE: bit_ok[b] = cur_i[b] & ~prev_i[b];
            COND_FALL: bit_ok[b] = ~cur_i[b] & prev_i[b];
            default:   bit_ok[b] = 1'b1;
         endcase
      end
   end

   assign hit_o = &bit_ok;

endmodule

// File: rtl/la_trig_seq.sv
module la_trig_seq #(
   parameter int STAGES = 4,
   localparam int SW = $clog2(STAGES + 1),
   localparam int IW = (STAGES > 1) ? $clog2(STAGES) : 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clear_i,
   input  logic              en_i,
   input  logic [STAGES-1:0] hit_i,
   input  logic [SW-1:0]     n_sel_i,
   output logic              fire_o
);

   logic [IW-1:0] stage_q;
   logic [IW-1:0] last_q;
   logic [SW-1:0] n_eff;
   logic          cur_hit;
   logic          at_last;

   always_comb begin
      if (n_sel_i == '0)
         n_eff = SW'(1);
      else if (n_sel_i > SW'(STAGES))
         n_eff = SW'(STAGES);
      else
         n_eff = n_sel_i;
   end

   assign cur_hit = hit_i[stage_q];
   assign at_last = (stage_q == last_q);
   assign fire_o  = en_i & cur_hit & at_last;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         stage_q <= '0;
         last_q  <= '0;
      end else if (clear_i) begin
         stage_q <= '0;
         last_q  <= IW'(n_eff - SW'(1));
      end else if (en_i && cur_hit) begin
         stage_q <= at_last ? '0 : stage_q + IW'(1);
      end
   end

endmodule

// File: rtl/la_ctrl.sv
module la_ctrl
   import la_pkg::*;
#(
   parameter int DEPTH = 64,
   localparam int AW = $clog2(DEPTH)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          arm_i,
   input  logic [1:0]    pos_i,
   input  logic          fire_i,
   output logic          we_o,
   output logic [AW-1:0] wr_addr_o,
   output logic          qual_o,
   output logic          busy_o,
   output logic          done_o,
   output logic [AW-1:0] trig_addr_o,
   output logic [AW-1:0] win_base_o
);

   la_state_e     state_q;
   logic [AW-1:0] wr_ptr_q;
   logic [AW-1:0] fill_q;
   logic [AW-1:0] pre_q;
   logic [AW-1:0] post_left_q;
   logic [AW-1:0] trig_q;
   logic          done_q;
   logic [AW:0]   post_total;
   logic [AW-1:0] pre_sel;

   assign pre_sel    = AW'(pre_count(DEPTH, pos_i));
   assign post_total = (AW+1)'(DEPTH) - {1'b0, pre_q};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q     <= ST_IDLE;
         wr_ptr_q    <= '0;
         fill_q      <= '0;
         pre_q       <= '0;
         post_left_q <= '0;
         trig_q      <= '0;
         done_q      <= 1'b0;
      end else if (arm_i) begin
         state_q  <= ST_PRE;
         wr_ptr_q <= '0;
         fill_q   <= '0;
         pre_q    <= pre_sel;
         done_q   <= 1'b0;
      end else begin
         case (state_q)
            ST_PRE: begin
               wr_ptr_q <= wr_ptr_q + AW'(1);
               if (fill_q != pre_q)
                  fill_q <= fill_q + AW'(1);
               if (fire_i) begin
                  trig_q <= wr_ptr_q;
                  if (post_total == (AW+1)'(1)) begin
                     state_q <= ST_DONE;
                     done_q  <= 1'b1;
                  end else begin
                     state_q     <= ST_POST;
                     post_left_q <= AW'(post_total - (AW+1)'(1));
                  end
               end
            end
            ST_POST: begin
               wr_ptr_q <= wr_ptr_q + AW'(1);
               if (post_left_q == AW'(1)) begin
                  state_q <= ST_DONE;
                  done_q  <= 1'b1;
               end else begin
                  post_left_q <= post_left_q - AW'(1);
               end
            end
            default: ;
         endcase
      end
   end

   assign we_o        = (state_q == ST_PRE) || (state_q == ST_POST);
   assign busy_o      = we_o;
   assign wr_addr_o   = wr_ptr_q;
   assign qual_o      = (state_q == ST_PRE) && (fill_q == pre_q);
   assign done_o      = done_q;
   assign trig_addr_o = trig_q;
   assign win_base_o  = trig_q - pre_q;

endmodule

// File: rtl/la_ring_mem.sv
module la_ring_mem #(
   parameter int WIDTH = 8,
   parameter int DEPTH = 64,
   localparam int AW = $clog2(DEPTH)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             we_i,
   input  logic [AW-1:0]    wa_i,
   input  logic [WIDTH-1:0] wd_i,
   input  logic             re_i,
   input  logic [AW-1:0]    ra_i,
   output logic             rv_o,
   output logic [WIDTH-1:0] rd_o
);

   logic [WIDTH-1:0] store [DEPTH];

   always_ff @(posedge clk) begin
      if (we_i)
         store[wa_i] <= wd_i;
      if (re_i)
         rd_o <= store[ra_i];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         rv_o <= 1'b0;
      else
         rv_o <= re_i;
   end

endmodule

// File: rtl/la_capture_core.sv
module la_capture_core
   import la_pkg::*;
#(
   parameter int PROBE_W = 8,
   parameter int DEPTH   = 64,
   parameter int STAGES  = 4,
   localparam int AW = $clog2(DEPTH),
   localparam int SW = $clog2(STAGES + 1),
   localparam int CW = 3 * PROBE_W
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 arm,
   input  logic [PROBE_W-1:0]   probe,
   input  logic [STAGES*CW-1:0] trig_cond,
   input  logic [SW-1:0]        n_stages,
   input  logic [1:0]           trig_pos,
   input  logic                 rd_en,
   input  logic [AW-1:0]        rd_addr,
   output logic                 busy,
   output logic                 done,
   output logic [AW-1:0]        trig_addr,
   output logic                 rd_valid,
   output logic [PROBE_W-1:0]   rd_data
);

   if (DEPTH < 8 || (1 << AW) != DEPTH) begin : g_bad_depth
      $error("DEPTH must be a power of two of at least 8");
   end
   if (PROBE_W < 1) begin : g_bad_width
      $error("PROBE_W must be at least 1");
   end
   if (STAGES < 1) begin : g_bad_stages
      $error("STAGES must be at least 1");
   end

   logic [PROBE_W-1:0] prev_q;
   logic [STAGES-1:0]  stage_hit;
   logic               fire;
   logic               qual;
   logic               mem_we;
   logic [AW-1:0]      wr_addr;
   logic [AW-1:0]      win_base;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         prev_q <= '0;
      else
         prev_q <= probe;
   end

   for (genvar s = 0; s < STAGES; s++) begin : g_stage
      la_trig_match #(.PROBE_W(PROBE_W)) u_match (
         .cur_i  (probe),
         .prev_i (prev_q),
         .cond_i (trig_cond[s*CW +: CW]),
         .hit_o  (stage_hit[s])
      );
   end

   la_trig_seq #(.STAGES(STAGES)) u_seq (
      .clk     (clk),
      .rst_n   (rst_n),
      .clear_i (arm),
      .en_i    (qual),
      .hit_i   (stage_hit),
      .n_sel_i (n_stages),
      .fire_o  (fire)
   );

   la_ctrl #(.DEPTH(DEPTH)) u_ctrl (
      .clk         (clk),
      .rst_n       (rst_n),
      .arm_i       (arm),
      .pos_i       (trig_pos),
      .fire_i      (fire),
      .we_o        (mem_we),
      .wr_addr_o   (wr_addr),
      .qual_o      (qual),
      .busy_o      (busy),
      .done_o      (done),
      .trig_addr_o (trig_addr),
      .win_base_o  (win_base)
   );

   la_ring_mem #(.WIDTH(PROBE_W), .DEPTH(DEPTH)) u_mem (
      .clk   (clk),
      .rst_n (rst_n),
      .we_i  (mem_we),
      .wa_i  (wr_addr),
      .wd_i  (probe),
      .re_i  (rd_en),
      .ra_i  (win_base + rd_addr),
      .rv_o  (rd_valid),
      .rd_o  (rd_data)
   );

endmodule

// File: rtl/la_capture_chk.sv
module la_capture_chk #(
   parameter int AW = 6
) (
   input logic          clk,
   input logic          rst_n,
   input logic          arm,
   input logic          busy,
   input logic          done,
   input logic [AW-1:0] trig_addr,
   input logic          rd_en,
   input logic          rd_valid,
   input logic          mem_we
);

   a_r7_busy_done_excl: assert property (@(posedge clk) disable iff (!rst_n)
      !(busy && done));

   a_r10_arm_restarts: assert property (@(posedge clk) disable iff (!rst_n)
      arm |=> (busy && !done));

   a_r7_freeze_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (done && !arm) |=> (done && $stable(trig_addr)));

   a_r7_no_write_frozen: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> !mem_we);

   a_r7_done_after_busy: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(done) |-> $past(busy));

   a_r8_read_latency: assert property (@(posedge clk) disable iff (!rst_n)
      rd_en |=> rd_valid);

   a_r8_no_spurious_valid: assert property (@(posedge clk) disable iff (!rst_n)
      !rd_en |=> !rd_valid);

endmodule

bind la_capture_core la_capture_chk #(.AW(AW)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .arm       (arm),
   .busy      (busy),
   .done      (done),
   .trig_addr (trig_addr),
   .rd_en     (rd_en),
   .rd_valid  (rd_valid),
   .mem_we    (mem_we)
);

// File: tb/sim_la_capture_core.sv
module sim_la_capture_core;

   localparam int W  = 8;
   localparam int D  = 64;
   localparam int NS = 4;
   localparam int AW = $clog2(D);
   localparam int SW = $clog2(NS + 1);
   localparam int CW = 3 * W;

   logic            clk = 1'b0;
   logic            rst_n = 1'b0;
   logic            arm = 1'b0;
   logic [W-1:0]    probe = '0;
   logic [NS*CW-1:0] cond = '0;
   logic [SW-1:0]   nst = SW'(1);
   logic [1:0]      pos = 2'd0;
   logic            rd_en = 1'b0;
   logic [AW-1:0]   rd_addr = '0;
   logic            busy, done, rd_valid;
   logic [AW-1:0]   trig_addr;
   logic [W-1:0]    rd_data;

   int total = 0;
   int bad   = 0;
   int pmode = 0, pbase = 0, pperiod = 1;

   always #10 clk = ~clk;

   la_capture_core #(.PROBE_W(W), .DEPTH(D), .STAGES(NS)) u0 (
      .clk(clk), .rst_n(rst_n), .arm(arm), .probe(probe), .trig_cond(cond),
      .n_stages(nst), .trig_pos(pos), .rd_en(rd_en), .rd_addr(rd_addr),
      .busy(busy), .done(done), .trig_addr(trig_addr),
      .rd_valid(rd_valid), .rd_data(rd_data)
   );

   task automatic check(input string req, input int act, input int exp);
      total++;
      if (act != exp) begin
         bad++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   function automatic logic [W-1:0] pat(input int i);
      if (i < 0) return '0;
      case (pmode)
         0: return W'(pbase + i);
         1: return W'(pbase + (i % pperiod));
         default: begin
            case (i % 12)
               0, 3, 6: return 8'h33;
               1, 5:    return 8'h11;
               4:       return 8'h22;
               default: return W'(8'h40 + i % 12);
            endcase
         end
      endcase
   endfunction

   function automatic int pre_of(input logic [1:0] p);
      return (p == 2'd0) ? D / 8 : (p == 2'd2) ? 7 * D / 8 : D / 2;
   endfunction

   function automatic logic bit_ok(input logic [2:0] c, input logic v, input logic pv);
      case (c)
         3'd1: return !v;
         3'd2: return v;
         3'd3: return v && !pv;
         3'd4: return !v && pv;
         default: return 1'b1;
      endcase
   endfunction

   // reference model: index of the trigger sample, per R2..R6
   function automatic int model_k(input logic [1:0] p, input int n);
      int eff = (n == 0) ? 1 : (n > NS) ? NS : n;
      int st = 0;
      for (int i = 0; i < 4000; i++) begin
         logic [W-1:0] v = pat(i);
         logic [W-1:0] pv = pat(i - 1);
         logic all = 1'b1;
         if (i < pre_of(p)) continue;
         for (int b = 0; b < W; b++)
            if (!bit_ok(cond[(st*W + b)*3 +: 3], v[b], pv[b])) all = 1'b0;
         if (all) begin
            if (st == eff - 1) return i;
            st++;
         end
      end
      return -1;
   endfunction

   function automatic logic [CW-1:0] exact(input logic [W-1:0] v);
      logic [CW-1:0] w;
      for (int b = 0; b < W; b++) w[3*b +: 3] = v[b] ? 3'd2 : 3'd1;
      return w;
   endfunction

   task automatic pulse_arm();
      @(negedge clk);
      arm = 1'b1;
      probe = '0;
      @(negedge clk);
      arm = 1'b0;
      check("R10 busy after arm", busy, 1);
      check("R10 done cleared by arm", done, 0);
   endtask

   // arm, stream samples until done, then freeze and read the window
   task automatic run(input string name, input logic [1:0] p, input int n);
      int k, pre, samples, errs;
      pos = p;
      nst = SW'(n);
      k = model_k(p, n);
      pre = pre_of(p);
      pulse_arm();
      samples = -1;
      for (int i = 0; i < 4000; i++) begin
         probe = pat(i);
         @(negedge clk);
         if (done) begin
            samples = i + 1;
            break;
         end
      end
      check({name, " R7 samples stored before done"}, samples, k + D - pre);
      check({name, " R9 trigger address"}, trig_addr, k % D);
      check({name, " R7 busy low when frozen"}, busy, 0);
      for (int j = 0; j < 20; j++) begin
         probe = ~pat(j);
         @(negedge clk);
      end
      errs = 0;
      for (int r = 0; r < D; r++) begin
         rd_en = 1'b1;
         rd_addr = AW'(r);
         @(negedge clk);
         if (rd_data !== pat(k - pre + r) || rd_valid !== 1'b1) begin
            errs++;
            if (errs == 1)
               $display("FAIL %s R8 window[%0d] actual=%0d expected=%0d",
                        name, r, rd_data, pat(k - pre + r));
         end
      end
      rd_en = 1'b0;
      total++;
      if (errs != 0) bad++;
      @(negedge clk);
      check({name, " R8 rd_valid drops"}, rd_valid, 0);
   endtask

   task automatic t_reset();
      check("R11 busy at reset", busy, 0);
      check("R11 done at reset", done, 0);
      check("R11 trig_addr at reset", trig_addr, 0);
      check("R11 rd_valid at reset", rd_valid, 0);
   endtask

   task automatic t_pre_exact();   // R1 R5 R8 R9
      pmode = 0; pbase = 8'h10;
      cond = '0;
      cond[0 +: CW] = exact(8'h24);
      run("pre_exact", 2'd0, 1);
   endtask

   task automatic t_center_qual(); // R6: early matches at 5 and 25 are ignored
      pmode = 1; pbase = 8'hA0; pperiod = 20;
      cond = '0;
      cond[0 +: CW] = exact(8'hA5);
      check("R6 model trigger index", model_k(2'd1, 1), 45);
      run("center_qual", 2'd1, 1);
   endtask

   task automatic t_pos3();        // R5 code 3 behaves as centre
      pmode = 0; pbase = 8'h80;
      cond = '0;
      cond[0 +: CW] = exact(8'hB2);
      run("pos3", 2'd3, 1);
   endtask

   task automatic t_and_rise();    // R2 R3: bit3 rising AND bit5 high
      pmode = 0; pbase = 0;
      cond = '0;
      cond[3*3 +: 3] = 3'd3;
      cond[3*5 +: 3] = 3'd2;
      cond[3*1 +: 3] = 3'd6;        // R3 code 6 is don't-care
      check("R2 model trigger index", model_k(2'd0, 1), 40);
      run("and_rise", 2'd0, 1);
   endtask

   task automatic t_post_fall();   // R3 falling edge, R5 late position
      pmode = 0; pbase = 0;
      cond = '0;
      cond[3*7 +: 3] = 3'd4;
      run("post_fall", 2'd2, 1);
   endtask

   task automatic t_sequence();    // R4 stages in order on distinct samples
      pmode = 2;
      cond = '0;
      cond[0*CW +: CW] = exact(8'h11);
      cond[1*CW +: CW] = exact(8'h22);
      cond[2*CW +: CW] = exact(8'h33);
      check("R4 model trigger index", model_k(2'd0, 3), 18);
      run("sequence", 2'd0, 3);
   endtask

   task automatic t_zero_stages(); // R4 count 0 acts as 1
      pmode = 2;
      run("zero_stages", 2'd0, 0);
   endtask

   task automatic t_rearm_busy();  // R10 restart while busy resets stages
      pmode = 0; pbase = 0;
      cond = '0;
      cond[0*CW +: CW] = exact(8'd9);
      cond[1*CW +: CW] = exact(8'd40);
      pos = 2'd0;
      nst = SW'(2);
      pulse_arm();
      for (int i = 0; i < 15; i++) begin
         probe = pat(i);
         @(negedge clk);
      end
      check("R10 still busy mid-capture", busy, 1);
      pbase = 30;
      run("rearm_busy", 2'd0, 2);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      bad++;
      total++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      @(negedge clk);
      t_pre_exact();
      t_center_qual();
      t_pos3();
      t_and_rise();
      t_post_fall();
      t_sequence();
      t_zero_stages();
      t_rearm_busy();
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule